// File: doc/BRIEF.md
# Preset-Path Message Router

This block is the forwarding core of a hub that links ten processing nodes. Each node owns a 16-bit write port and a receive queue. Addressing is set up in advance instead of being carried with the words. A node first writes a destination node number into its own route register. Every data word it writes after that goes to that destination's receive queue until the node writes a new route. As a result, the payload words carry no header, which suits long streams such as image frames.

Each write carries a two-bit register select. That select marks the write as payload, a route update or a command. Commands stay inside the hub and are never forwarded. When several nodes stream into the same destination in the same cycle, a rotating-priority arbiter for that destination accepts one of them. The other senders are held with a per-port wait signal until their turn comes. A full receive queue holds every sender aimed at it in the same way, so no word is lost. Each queue entry carries a tag bit that marks it as payload. A payload word written while the sender's route is unusable is discarded, and the sender's sticky error flag is raised.

Top module: `preset_path_router`

## Requirements
- R1: After reset every route register holds an invalid value, every error flag is 0, every receive queue is empty and no wait signal is raised.
- R2: A payload write (select 2'b00), accepted while the sender's route is valid, appears at the head of the routed destination's receive queue on the next cycle with its tag bit at 1. Words from one sender come out in the order they were written.
- R3: A route write (select 2'b01) loads bits [3:0] of the written word into the sender's route register. The new route applies to every payload write accepted after the route write, including one issued in the very next cycle.
- R4: A payload write made while the route is 10 to 15 (or still at its reset value) is accepted at once without a wait. Nothing reaches any queue, and the sender's error flag is set. The flag stays set until it is cleared.
- R5: A command write (select 2'b10) is never forwarded and never waits. If its bit 0 is 1 it clears the sender's error flag; its other bits have no effect.
- R6: Among the senders whose accepted payload targets the same destination in one cycle, exactly one is accepted. The winner is the first requester after the previous winner in ascending cyclic node order. The first search after reset starts at node 0. Every other requester sees its wait signal high.
- R7: While a destination queue (4 entries by default) is full, every payload write aimed at it waits and nothing in the queue changes. Once a word is popped, the held write is accepted in a following cycle.
- R8: A pop strobe on a non-empty queue removes its head at the clock edge. A pop strobe on an empty queue has no effect.
- R9: Select value 2'b11 is ignored: no forwarding, no route change, no flag change, no wait.
- R10: Payload writes from different senders to different destinations are all accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 10 | Per-node write strobe, held until accepted |
| wrSel | input | 20 | Per-node register select, 2 bits per node (00 payload, 01 route, 10 command, 11 none) |
| wrData | input | 160 | Per-node write word, 16 bits per node |
| busy | output | 10 | Per-node wait: the current payload write is not accepted this cycle |
| errFlag | output | 10 | Per-node sticky flag for payload discarded on an invalid route |
| rxValid | output | 10 | Per-node receive queue not empty |
| rxData | output | 160 | Per-node head word of the receive queue, 16 bits per node |
| rxTag | output | 10 | Per-node head tag, 1 for payload |
| rxPop | input | 10 | Per-node strobe that removes the head word |

## Verification
Two pieces of arbitration can fall in the same cycle. One is the rotating choice among senders aimed at one destination. The other is the hold caused by that destination's full queue. The bench fills a queue by letting three senders collide on it, then tops it up and holds a further write against it. It judges the wait signals in each cycle against the expected cyclic winner. After a single pop releases the held word, it drains the queue and compares the word order with the order worked out from the rotation rule.

// File: rtl/ppr_pkg.sv
`timescale 1ns/1ps
package ppr_pkg;
  parameter int NODE_COUNT = 10;
  parameter int WORD_W = 16;
  parameter int NODE_W = $clog2(NODE_COUNT);

  typedef enum logic [1:0] {
    SEL_DATA = 2'b00,
    SEL_PATH = 2'b01,
    SEL_CTRL = 2'b10,
    SEL_NONE = 2'b11
  } sel_e;

  typedef struct packed {
    logic [NODE_COUNT-1:0]             pushEn;
    logic [NODE_COUNT-1:0][NODE_W-1:0] pushSrc;
  } strobe_t;
endpackage

// File: rtl/ppr_arbiter.sv
`timescale 1ns/1ps
module ppr_arbiter #(
  parameter int WAYS = 10,
  localparam int IW = $clog2(WAYS)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [WAYS-1:0] req,
  input  logic            en,
  output logic [WAYS-1:0] grant,
  output logic [IW-1:0]   grantIdx
);
  logic [IW-1:0] lastIdx;
  logic          anyReq;

  always_comb begin
    grant    = '0;
    grantIdx = '0;
    anyReq   = 1'b0;
    for (int k = 1; k <= WAYS; k++) begin
      int j;
      j = int'(lastIdx) + k;
      if (j >= WAYS) j = j - WAYS;
      if (!anyReq && req[IW'(j)]) begin
        anyReq   = 1'b1;
        grantIdx = IW'(j);
      end
    end
    if (en && anyReq) grant[grantIdx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) lastIdx <= IW'(WAYS - 1);
    else if (en && anyReq) lastIdx <= grantIdx;
  end
endmodule

// File: rtl/ppr_ctrl.sv
`timescale 1ns/1ps
module ppr_ctrl
  import ppr_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [NODE_COUNT-1:0]            wrEn,
  input  logic [NODE_COUNT-1:0][1:0]       wrSel,
  input  logic [NODE_COUNT-1:0][NODE_W-1:0] pathField,
  input  logic [NODE_COUNT-1:0]            ctrlBit,
  input  logic [NODE_COUNT-1:0]            qFull,
  output logic [NODE_COUNT-1:0]            busy,
  output logic [NODE_COUNT-1:0]            errFlag,
  output strobe_t                          strobe
);
  logic [NODE_COUNT-1:0][NODE_W-1:0] pathReg;
  logic [NODE_COUNT-1:0]             routeOk;
  logic [NODE_COUNT-1:0]             dataReq;
  logic [NODE_COUNT-1:0]             dropSet;
  logic [NODE_COUNT-1:0]             wonAny;
  logic [NODE_COUNT-1:0][NODE_COUNT-1:0] reqMat;
  logic [NODE_COUNT-1:0][NODE_COUNT-1:0] grantMat;

  always_comb begin
    for (int s = 0; s < NODE_COUNT; s++) begin
      routeOk[s] = pathReg[s] < NODE_W'(NODE_COUNT);
      dataReq[s] = wrEn[s] && (wrSel[s] == SEL_DATA);
      dropSet[s] = dataReq[s] && !routeOk[s];
    end
    for (int d = 0; d < NODE_COUNT; d++)
      for (int s = 0; s < NODE_COUNT; s++)
        reqMat[d][s] = dataReq[s] && routeOk[s] && (pathReg[s] == NODE_W'(d));
  end

  for (genvar d = 0; d < NODE_COUNT; d++) begin : g_dest
    ppr_arbiter #(.WAYS(NODE_COUNT)) u_arb (
      .clk      (clk),
      .rstN     (rstN),
      .req      (reqMat[d]),
      .en       (!qFull[d]),
      .grant    (grantMat[d]),
      .grantIdx (strobe.pushSrc[d])
    );
    assign strobe.pushEn[d] = |grantMat[d];
  end

  always_comb begin
    wonAny = '0;
    for (int d = 0; d < NODE_COUNT; d++) wonAny = wonAny | grantMat[d];
    for (int s = 0; s < NODE_COUNT; s++)
      busy[s] = dataReq[s] && routeOk[s] && !wonAny[s];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pathReg <= '1;
      errFlag <= '0;
    end else begin
      for (int s = 0; s < NODE_COUNT; s++) begin
        if (wrEn[s] && wrSel[s] == SEL_PATH) pathReg[s] <= pathField[s];
        if (dropSet[s]) errFlag[s] <= 1'b1;
        else if (wrEn[s] && wrSel[s] == SEL_CTRL && ctrlBit[s]) errFlag[s] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ppr_fifo.sv
`timescale 1ns/1ps
module ppr_fifo #(
  parameter int WIDTH = 17,
  parameter int DEPTH = 4,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushWord,
  input  logic             pop,
  output logic [WIDTH-1:0] headWord,
  output logic             empty,
  output logic             full
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrIdx, rdIdx;
  logic [AW:0]      fill;
  logic             doPush, doPop;

  assign empty    = (fill == '0);
  assign full     = (fill == (AW+1)'(DEPTH));
  assign doPush   = push && !full;
  assign doPop    = pop && !empty;
  assign headWord = mem[rdIdx];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrIdx] <= pushWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrIdx <= '0;
      rdIdx <= '0;
      fill  <= '0;
    end else begin
      if (doPush) wrIdx <= (wrIdx == AW'(DEPTH-1)) ? '0 : wrIdx + 1'b1;
      if (doPop)  rdIdx <= (rdIdx == AW'(DEPTH-1)) ? '0 : rdIdx + 1'b1;
      if (doPush && !doPop) fill <= fill + 1'b1;
      else if (doPop && !doPush) fill <= fill - 1'b1;
    end
  end
endmodule

// File: rtl/ppr_datapath.sv
`timescale 1ns/1ps
module ppr_datapath
  import ppr_pkg::*;
#(
  parameter int QUEUE_DEPTH = 4
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [NODE_COUNT-1:0][WORD_W-1:0] wrData,
  input  strobe_t                          strobe,
  input  logic [NODE_COUNT-1:0]            rxPop,
  output logic [NODE_COUNT-1:0]            qFull,
  output logic [NODE_COUNT-1:0]            rxValid,
  output logic [NODE_COUNT-1:0][WORD_W-1:0] rxData,
  output logic [NODE_COUNT-1:0]            rxTag
);
  localparam int ENTRY_W = WORD_W + 1;

  for (genvar d = 0; d < NODE_COUNT; d++) begin : g_queue
    logic [ENTRY_W-1:0] inWord, outWord;
    logic               isEmpty;

    assign inWord = {1'b1, wrData[strobe.pushSrc[d]]};

    ppr_fifo #(.WIDTH(ENTRY_W), .DEPTH(QUEUE_DEPTH)) u_fifo (
      .clk      (clk),
      .rstN     (rstN),
      .push     (strobe.pushEn[d]),
      .pushWord (inWord),
      .pop      (rxPop[d]),
      .headWord (outWord),
      .empty    (isEmpty),
      .full     (qFull[d])
    );

    assign rxValid[d] = !isEmpty;
    assign rxData[d]  = outWord[WORD_W-1:0];
    assign rxTag[d]   = !isEmpty && outWord[WORD_W];
  end
endmodule

// File: rtl/preset_path_router.sv
`timescale 1ns/1ps
module preset_path_router
  import ppr_pkg::*;
#(
  parameter int QUEUE_DEPTH = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NODE_COUNT-1:0]          wrEn,
  input  logic [2*NODE_COUNT-1:0]        wrSel,
  input  logic [WORD_W*NODE_COUNT-1:0]   wrData,
  output logic [NODE_COUNT-1:0]          busy,
  output logic [NODE_COUNT-1:0]          errFlag,
  output logic [NODE_COUNT-1:0]          rxValid,
  output logic [WORD_W*NODE_COUNT-1:0]   rxData,
  output logic [NODE_COUNT-1:0]          rxTag,
  input  logic [NODE_COUNT-1:0]          rxPop
);
  logic [NODE_COUNT-1:0][1:0]        selA;
  logic [NODE_COUNT-1:0][WORD_W-1:0] dataA;
  logic [NODE_COUNT-1:0][WORD_W-1:0] rxDataA;
  logic [NODE_COUNT-1:0][NODE_W-1:0] pathField;
  logic [NODE_COUNT-1:0]             ctrlBit;
  logic [NODE_COUNT-1:0]             qFull;
  strobe_t                           strobe;

  assign selA   = wrSel;
  assign dataA  = wrData;
  assign rxData = rxDataA;

  for (genvar n = 0; n < NODE_COUNT; n++) begin : g_split
    assign pathField[n] = dataA[n][NODE_W-1:0];
    assign ctrlBit[n]   = dataA[n][0];
  end

  ppr_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrSel     (selA),
    .pathField (pathField),
    .ctrlBit   (ctrlBit),
    .qFull     (qFull),
    .busy      (busy),
    .errFlag   (errFlag),
    .strobe    (strobe)
  );

  ppr_datapath #(.QUEUE_DEPTH(QUEUE_DEPTH)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .wrData  (dataA),
    .strobe  (strobe),
    .rxPop   (rxPop),
    .qFull   (qFull),
    .rxValid (rxValid),
    .rxData  (rxDataA),
    .rxTag   (rxTag)
  );
endmodule

// File: rtl/ppr_checker.sv
`timescale 1ns/1ps
module ppr_checker
  import ppr_pkg::*;
(
  input logic                    clk,
  input logic                    rstN,
  input logic [NODE_COUNT-1:0]   wrEn,
  input logic [2*NODE_COUNT-1:0] wrSel,
  input logic [NODE_COUNT-1:0]   busy,
  input logic [NODE_COUNT-1:0]   errFlag,
  input logic [NODE_COUNT-1:0]   rxValid,
  input logic [NODE_COUNT-1:0]   qFull,
  input strobe_t                 strobe
);
  logic [NODE_COUNT-1:0][NODE_COUNT-1:0] srcHit;

  always_comb begin
    for (int s = 0; s < NODE_COUNT; s++)
      for (int d = 0; d < NODE_COUNT; d++)
        srcHit[s][d] = strobe.pushEn[d] && (strobe.pushSrc[d] == NODE_W'(s));
  end

  // R1: queues and flags come out of reset clear
  a_r1_reset_clear: assert property (@(posedge clk)
    $rose(rstN) |-> (rxValid == '0) && (errFlag == '0));

  for (genvar n = 0; n < NODE_COUNT; n++) begin : g_node
    // R2: a push always comes from a sender presenting payload without a wait
    a_r2_push_from_sender: assert property (@(posedge clk) disable iff (!rstN)
      strobe.pushEn[n] |-> wrEn[strobe.pushSrc[n]] && !busy[strobe.pushSrc[n]] &&
      (wrSel[2*strobe.pushSrc[n] +: 2] == SEL_DATA));
    // R4: error flag only rises after a payload write by that node
    a_r4_err_cause: assert property (@(posedge clk) disable iff (!rstN)
      $rose(errFlag[n]) |-> $past(wrEn[n] && wrSel[2*n +: 2] == SEL_DATA));
    // R5, R9: route, command and ignored selects never wait
    a_r5_nonpayload_no_wait: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn[n] && wrSel[2*n +: 2] != SEL_DATA) |-> !busy[n]);
    // R6: one sender lands in at most one queue per cycle
    a_r6_single_target: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(srcHit[n]));
    // R7: a full queue receives nothing
    a_r7_full_no_push: assert property (@(posedge clk) disable iff (!rstN)
      qFull[n] |-> !strobe.pushEn[n]);
    // R8: an empty queue with no push stays empty whatever the pop strobe does
    a_r8_empty_stays: assert property (@(posedge clk) disable iff (!rstN)
      (!rxValid[n] && !strobe.pushEn[n]) |=> !rxValid[n]);
  end
endmodule

bind preset_path_router ppr_checker u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .wrSel   (wrSel),
  .busy    (busy),
  .errFlag (errFlag),
  .rxValid (rxValid),
  .qFull   (qFull),
  .strobe  (strobe)
);

// File: tb/preset_path_router_test.sv
`timescale 1ns/1ps
module preset_path_router_test;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [9:0]   wrEn = '0;
  logic [19:0]  wrSel = '0;
  logic [159:0] wrData = '0;
  logic [9:0]   rxPop = '0;
  logic [9:0]   busy, errFlag, rxValid, rxTag;
  logic [159:0] rxData;
  int checks = 0;
  int failures = 0;

  localparam logic [1:0] D = 2'b00, P = 2'b01, C = 2'b10, X = 2'b11;
  // {src[3:0], sel[1:0], word[15:0], expected destination (15 = none), expected error flag}
  localparam logic [26:0] VEC [0:17] = '{
    {4'd0, P, 16'h0003, 4'd15, 1'b0},  // R3 route 0->3
    {4'd0, D, 16'hA001, 4'd3,  1'b0},  // R2 R3
    {4'd0, D, 16'hA002, 4'd3,  1'b0},  // R2
    {4'd0, P, 16'h0007, 4'd15, 1'b0},  // R3 reroute
    {4'd0, D, 16'hA003, 4'd7,  1'b0},  // R3 next write uses new route
    {4'd2, D, 16'hB000, 4'd15, 1'b1},  // R4 reset route invalid
    {4'd2, C, 16'h0002, 4'd15, 1'b1},  // R5 bit0 clear: no effect
    {4'd2, C, 16'h0001, 4'd15, 1'b0},  // R5 clear flag
    {4'd5, P, 16'h000C, 4'd15, 1'b0},  // R4 route 12
    {4'd5, D, 16'hC000, 4'd15, 1'b1},  // R4 dropped
    {4'd5, P, 16'h0009, 4'd15, 1'b1},  // R4 flag sticky
    {4'd5, D, 16'hC001, 4'd9,  1'b1},  // R2 top node
    {4'd5, C, 16'h0001, 4'd15, 1'b0},  // R5
    {4'd9, X, 16'h0005, 4'd15, 1'b0},  // R9 ignored
    {4'd9, D, 16'hD000, 4'd15, 1'b1},  // R9 route still invalid
    {4'd9, C, 16'h0001, 4'd15, 1'b0},  // R5
    {4'd9, P, 16'h0000, 4'd15, 1'b0},  // R3 route to node 0
    {4'd9, D, 16'hD001, 4'd0,  1'b0}   // R2 bottom node
  };

  preset_path_router uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .busy(busy), .errFlag(errFlag), .rxValid(rxValid), .rxData(rxData),
    .rxTag(rxTag), .rxPop(rxPop)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setWr(input int n, input logic [1:0] s, input logic [15:0] d);
    wrEn[n] = 1'b1;
    wrSel[2*n +: 2] = s;
    wrData[16*n +: 16] = d;
  endtask

  task automatic putWord(input int n, input logic [1:0] s, input logic [15:0] d);
    logic b;
    @(negedge clk);
    setWr(n, s, d);
    do begin
      #1 b = busy[n];
      @(posedge clk);
      if (b) @(negedge clk);
    end while (b);
    @(negedge clk);
    wrEn[n] = 1'b0;
  endtask

  task automatic popNode(input int n);
    rxPop[n] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rxPop[n] = 1'b0;
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [26:0] v;
    int src, dest;
    logic [1:0] sel;
    logic [15:0] wd;
    logic er;
    logic [15:0] order [4];

    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R1 rxValid", 32'(rxValid), 0);
    chk("R1 errFlag", 32'(errFlag), 0);
    chk("R1 busy", 32'(busy), 0);

    for (int i = 0; i < 18; i++) begin
      v = VEC[i];
      src = int'(v[26:23]); sel = v[22:21]; wd = v[20:5];
      dest = int'(v[4:1]); er = v[0];
      putWord(src, sel, wd);
      chk("R2/R3/R4/R9 rxValid", 32'(rxValid), (dest < 10) ? (32'd1 << dest) : 32'd0);
      if (dest < 10) begin
        chk("R2 rxData", 32'(rxData[16*dest +: 16]), 32'(wd));
        chk("R2 rxTag", 32'(rxTag[dest]), 1);
        popNode(dest);
      end
      chk("R4/R5 errFlag", 32'(errFlag[src]), 32'(er));
    end

    // R6: three senders collide on node 8
    putWord(1, P, 16'h0008);
    putWord(4, P, 16'h0008);
    putWord(6, P, 16'h0008);
    @(negedge clk);
    setWr(1, D, 16'hE001); setWr(4, D, 16'hE004); setWr(6, D, 16'hE006);
    #1 chk("R6 first winner node 1", 32'(busy), 32'h050);
    @(posedge clk); @(negedge clk); wrEn[1] = 1'b0;
    #1 chk("R6 second winner node 4", 32'(busy), 32'h040);
    @(posedge clk); @(negedge clk); wrEn[4] = 1'b0;
    #1 chk("R6 third winner node 6", 32'(busy), 32'h000);
    @(posedge clk); @(negedge clk); wrEn[6] = 1'b0;
    chk("R6 head", 32'(rxData[16*8 +: 16]), 32'hE001);

    // R7: fill to four entries, then hold a fifth write
    putWord(1, D, 16'hE011);
    setWr(1, D, 16'hE012);
    #1 chk("R7 wait on full", 32'(busy[1]), 1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1 chk("R7 still waiting", 32'(busy[1]), 1);
    chk("R7 head unchanged", 32'(rxData[16*8 +: 16]), 32'hE001);
    rxPop[8] = 1'b1;
    @(posedge clk); @(negedge clk); rxPop[8] = 1'b0;
    #1 chk("R7 released after pop", 32'(busy[1]), 0);
    @(posedge clk); @(negedge clk); wrEn[1] = 1'b0;
    order = '{16'hE004, 16'hE006, 16'hE011, 16'hE012};
    for (int k = 0; k < 4; k++) begin
      chk("R7/R6 drain order", 32'(rxData[16*8 +: 16]), 32'(order[k]));
      popNode(8);
    end
    chk("R8 drained", 32'(rxValid[8]), 0);

    // R6: rotation, last winner was node 1 so node 4 goes first
    setWr(1, D, 16'hF001); setWr(4, D, 16'hF004);
    #1 chk("R6 rotation", 32'(busy), 32'h002);
    @(posedge clk); @(negedge clk); wrEn[4] = 1'b0;
    #1 chk("R6 rotation second", 32'(busy), 32'h000);
    @(posedge clk); @(negedge clk); wrEn[1] = 1'b0;
    chk("R6 rotation head", 32'(rxData[16*8 +: 16]), 32'hF004);
    popNode(8);
    chk("R6 rotation tail", 32'(rxData[16*8 +: 16]), 32'hF001);
    popNode(8);

    // R10: parallel delivery to distinct nodes
    putWord(3, P, 16'h0002);
    putWord(7, P, 16'h0005);
    @(negedge clk);
    setWr(3, D, 16'h1232); setWr(7, D, 16'h1275);
    #1 chk("R10 no wait", 32'(busy), 0);
    @(posedge clk); @(negedge clk); wrEn[3] = 1'b0; wrEn[7] = 1'b0;
    chk("R10 both valid", 32'(rxValid), 32'h024);
    chk("R10 data node 2", 32'(rxData[16*2 +: 16]), 32'h1232);
    chk("R10 data node 5", 32'(rxData[16*5 +: 16]), 32'h1275);
    popNode(2);
    popNode(5);

    // R8: pop strobe on an empty queue
    popNode(2);
    chk("R8 empty pop", 32'(rxValid), 0);
    putWord(3, D, 16'h2223);
    chk("R8 after empty pop", 32'(rxValid), 32'h004);
    chk("R8 data", 32'(rxData[16*2 +: 16]), 32'h2223);
    popNode(2);
    chk("R8 single entry", 32'(rxValid[2]), 0);

    finishRun();
  end
endmodule